// File: doc/BRIEF.md
# DRAM Clock Frequency Change Sequencer

This block is the controller-side sequencer that moves a running DDR memory device onto a new clock frequency. A request accepted while the block is ready starts a fixed series of steps. If a bank is open it first closes all banks and lets the precharge time pass. It then drops the clock-enable pin to put the device in precharge power-down. After the minimum number of low cycles it asks an external clock generator to retune. Clock-enable stays low until the generator reports a stable clock. The block then raises clock-enable, resets the device's DLL with an extended mode register command, and may rewrite the mode register to set a new CAS latency. It stays busy until the DLL relock time has passed.

The DRAM command bus is reduced to one-cycle command strobes. The block does not drive pin encodings. A memory controller holds off its normal traffic while `ready` is low and sends each strobe through its command path. All timing windows are parameters counted in memory clock cycles. They are `T_RP` (precharge), `T_CKE` (minimum low time, raised to 2 if set lower), `T_XP` (power-down exit), `T_MRD` (mode command spacing) and `T_RELOCK` (DLL relock). The parameters must satisfy `T_RELOCK >= T_MRD + 3`.

Top module: `dram_fchg_seq`

## Requirements
- R1: During and immediately after reset, `ready`=1, `cke`=1, and all command strobes and `freq_change_req` are 0.
- R2: `fchg_start` is accepted only on a clock edge where `ready` is 1. `ready` is 0 from the next cycle until the sequence ends. Requests, `bank_open` and `upd_cl_en` values seen while busy have no effect on the sequence.
- R3: With `bank_open`=1 at acceptance, `cmd_pre_all` pulses for exactly one cycle right after acceptance. It is followed by `T_RP` cycles with `cke`=1 and no strobes before `cke` falls.
- R4: With `bank_open`=0 at acceptance, there is no precharge strobe and `cke` falls in the cycle right after acceptance.
- R5: `cke` is low for max(`T_CKE`,2) cycles before `freq_change_req` rises.
- R6: `freq_change_req`=1 and `cke`=0 hold until the first edge at which `clk_stable` is 1 while `freq_change_req` is asserted. `clk_stable` is ignored in all other states.
- R7: `cke` rises in the cycle after `clk_stable` is accepted. After `T_XP` cycles with `cke` high, `cmd_emrs_dll_rst` pulses for one cycle.
- R8: If `upd_cl_en` was 1 at acceptance, `cmd_mrs` pulses once, `T_MRD`+1 cycles after the DLL reset strobe. Otherwise `cmd_mrs` stays 0.
- R9: `ready` returns to 1 exactly `T_RELOCK` cycles after the DLL reset strobe cycle. `cke` stays 1 from power-down exit onward.
- R10: At most one command strobe is active in any cycle. No strobe and no `freq_change_req` is active while `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| fchg_start | input | 1 | Frequency change request |
| bank_open | input | 1 | At least one bank is open, so precharge-all is needed |
| upd_cl_en | input | 1 | Issue a mode register write after the DLL reset |
| clk_stable | input | 1 | Clock generator reports the new clock is stable |
| ready | output | 1 | Device usable for normal traffic |
| cke | output | 1 | Clock-enable pin level |
| cmd_pre_all | output | 1 | One-cycle precharge-all strobe |
| cmd_emrs_dll_rst | output | 1 | One-cycle extended mode command strobe with DLL reset |
| cmd_mrs | output | 1 | One-cycle mode register write strobe |
| freq_change_req | output | 1 | Request to the clock generator to change frequency |

## Verification
Every output is a flop, so each response appears in the cycle after the edge that caused it. `ready` falls and the first step appears one cycle after acceptance. `cke` rises one cycle after `clk_stable` is seen. The DLL reset strobe follows `T_XP` cycles later, the mode write comes `T_MRD`+1 cycles after that, and `ready` returns `T_RELOCK` cycles after the DLL reset strobe. The bench's model advances on the same rising edge that the design uses. It compares the full output vector on the falling edge, half a cycle after each update. A wrong offset anywhere in the sequence therefore shows up in the exact cycle where it occurs.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_PRE_WAIT,
        ST_PDOWN,
        ST_FREQ,
        ST_EXIT,
        ST_EMRS,
        ST_MRD_WAIT,
        ST_MRS,
        ST_RELOCK
    } fcs_state_e;

    typedef struct packed {
        logic ready;
        logic cke;
        logic pre_all;
        logic emrs;
        logic mrs;
        logic freq_req;
    } fcs_pins_t;

    localparam int FCS_MIN_CKE_LOW = 2;

    function automatic int fcs_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic fcs_pins_t fcs_decode(input fcs_state_e s);
        fcs_pins_t p;
        p = '{ready: 1'b0, cke: 1'b1, pre_all: 1'b0, emrs: 1'b0, mrs: 1'b0, freq_req: 1'b0};
        case (s)
            ST_IDLE:  p.ready    = 1'b1;
            ST_PRE:   p.pre_all  = 1'b1;
            ST_PDOWN: p.cke      = 1'b0;
            ST_FREQ: begin
                p.cke      = 1'b0;
                p.freq_req = 1'b1;
            end
            ST_EMRS:  p.emrs     = 1'b1;
            ST_MRS:   p.mrs      = 1'b1;
            default:  ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/fcs_timer.sv
module fcs_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fcs_fsm.sv
module fcs_fsm
    import fcs_pkg::*;
#(
    parameter int               CNT_W  = 8,
    parameter logic [CNT_W-1:0] RP_M1  = '0,
    parameter logic [CNT_W-1:0] CKE_M1 = '0,
    parameter logic [CNT_W-1:0] XP_M1  = '0,
    parameter logic [CNT_W-1:0] MRD_M1 = '0,
    parameter logic [CNT_W-1:0] RL_M2  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             bank_open,
    input  logic             upd_cl_en,
    input  logic             clk_stable,
    input  logic             main_zero,
    input  logic             rl_zero,
    output fcs_state_e       state_d,
    output logic             main_load,
    output logic [CNT_W-1:0] main_val,
    output logic             rl_load,
    output logic [CNT_W-1:0] rl_val
);
    fcs_state_e state_q;
    logic       upd_q;

    always_comb begin
        state_d   = state_q;
        main_load = 1'b0;
        main_val  = '0;
        rl_load   = 1'b0;
        rl_val    = RL_M2;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (bank_open) begin
                        state_d = ST_PRE;
                    end else begin
                        state_d   = ST_PDOWN;
                        main_load = 1'b1;
                        main_val  = CKE_M1;
                    end
                end
            end
            ST_PRE: begin
                state_d   = ST_PRE_WAIT;
                main_load = 1'b1;
                main_val  = RP_M1;
            end
            ST_PRE_WAIT: begin
                if (main_zero) begin
                    state_d   = ST_PDOWN;
                    main_load = 1'b1;
                    main_val  = CKE_M1;
                end
            end
            ST_PDOWN: begin
                if (main_zero) state_d = ST_FREQ;
            end
            ST_FREQ: begin
                if (clk_stable) begin
                    state_d   = ST_EXIT;
                    main_load = 1'b1;
                    main_val  = XP_M1;
                end
            end
            ST_EXIT: begin
                if (main_zero) state_d = ST_EMRS;
            end
            ST_EMRS: begin
                state_d   = ST_MRD_WAIT;
                main_load = 1'b1;
                main_val  = MRD_M1;
                rl_load   = 1'b1;
            end
            ST_MRD_WAIT: begin
                if (main_zero) state_d = upd_q ? ST_MRS : ST_RELOCK;
            end
            ST_MRS: begin
                state_d = ST_RELOCK;
            end
            ST_RELOCK: begin
                if (rl_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            upd_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                upd_q <= upd_cl_en;
            end
        end
    end
endmodule

// File: rtl/fcs_pin_drive.sv
module fcs_pin_drive
    import fcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fcs_state_e state_d,
    output fcs_pins_t  pins
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pins <= fcs_decode(ST_IDLE);
        end else begin
            pins <= fcs_decode(state_d);
        end
    end
endmodule

// File: rtl/dram_fchg_seq.sv
module dram_fchg_seq
    import fcs_pkg::*;
#(
    parameter int T_RP     = 3,
    parameter int T_CKE    = 2,
    parameter int T_XP     = 2,
    parameter int T_MRD    = 2,
    parameter int T_RELOCK = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic fchg_start,
    input  logic bank_open,
    input  logic upd_cl_en,
    input  logic clk_stable,
    output logic ready,
    output logic cke,
    output logic cmd_pre_all,
    output logic cmd_emrs_dll_rst,
    output logic cmd_mrs,
    output logic freq_change_req
);
    localparam int T_CKE_EFF = fcs_max(T_CKE, FCS_MIN_CKE_LOW);
    localparam int MAX_T     = fcs_max(fcs_max(fcs_max(T_RP, T_CKE_EFF),
                                               fcs_max(T_XP, T_MRD)), T_RELOCK);
    localparam int CNT_W     = $clog2(MAX_T + 1);

    localparam logic [CNT_W-1:0] RP_M1  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] CKE_M1 = CNT_W'(T_CKE_EFF - 1);
    localparam logic [CNT_W-1:0] XP_M1  = CNT_W'(T_XP - 1);
    localparam logic [CNT_W-1:0] MRD_M1 = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] RL_M2  = CNT_W'(T_RELOCK - 2);

    localparam int N_TIMERS = 2;

    fcs_state_e       state_d;
    logic             tmr_load [N_TIMERS];
    logic [CNT_W-1:0] tmr_val  [N_TIMERS];
    logic             tmr_zero [N_TIMERS];
    fcs_pins_t        pins;

    fcs_fsm #(
        .CNT_W (CNT_W),
        .RP_M1 (RP_M1),
        .CKE_M1(CKE_M1),
        .XP_M1 (XP_M1),
        .MRD_M1(MRD_M1),
        .RL_M2 (RL_M2)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (fchg_start),
        .bank_open (bank_open),
        .upd_cl_en (upd_cl_en),
        .clk_stable(clk_stable),
        .main_zero (tmr_zero[0]),
        .rl_zero   (tmr_zero[1]),
        .state_d   (state_d),
        .main_load (tmr_load[0]),
        .main_val  (tmr_val[0]),
        .rl_load   (tmr_load[1]),
        .rl_val    (tmr_val[1])
    );

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
        fcs_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk     (clk),
            .rst     (rst),
            .load    (tmr_load[g]),
            .load_val(tmr_val[g]),
            .zero    (tmr_zero[g])
        );
    end

    fcs_pin_drive u_pins (
        .clk    (clk),
        .rst    (rst),
        .state_d(state_d),
        .pins   (pins)
    );

    assign ready            = pins.ready;
    assign cke              = pins.cke;
    assign cmd_pre_all      = pins.pre_all;
    assign cmd_emrs_dll_rst = pins.emrs;
    assign cmd_mrs          = pins.mrs;
    assign freq_change_req  = pins.freq_req;
endmodule

// File: rtl/dram_fchg_seq_chk.sv
module dram_fchg_seq_chk (
    input logic clk,
    input logic rst,
    input logic fchg_start,
    input logic clk_stable,
    input logic ready,
    input logic cke,
    input logic cmd_pre_all,
    input logic cmd_emrs_dll_rst,
    input logic cmd_mrs,
    input logic freq_change_req
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ready && cke && !freq_change_req));

    a_r2_busy_start_no_pre: assert property (@(posedge clk) disable iff (rst)
        (!ready && fchg_start) |=> !cmd_pre_all);

    a_r3_pre_from_accept: assert property (@(posedge clk) disable iff (rst)
        cmd_pre_all |-> ($past(ready) && $past(fchg_start) && cke));

    a_r5_cke_low_before_req: assert property (@(posedge clk) disable iff (rst)
        $rose(freq_change_req) |-> ($past(!cke) && $past(!cke, 2)));

    a_r6_cke_low_with_req: assert property (@(posedge clk) disable iff (rst)
        freq_change_req |-> !cke);

    a_r6_req_drop_on_stable: assert property (@(posedge clk) disable iff (rst)
        $fell(freq_change_req) |-> (cke && $past(clk_stable)));

    a_r7_emrs_cke_high: assert property (@(posedge clk) disable iff (rst)
        cmd_emrs_dll_rst |-> (cke && $past(cke) && !ready));

    a_r8_mrs_busy: assert property (@(posedge clk) disable iff (rst)
        cmd_mrs |-> (cke && !ready));

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_pre_all, cmd_emrs_dll_rst, cmd_mrs}));

    a_r10_quiet_when_ready: assert property (@(posedge clk) disable iff (rst)
        ready |-> (cke && !cmd_pre_all && !cmd_emrs_dll_rst && !cmd_mrs && !freq_change_req));
endmodule

bind dram_fchg_seq dram_fchg_seq_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .fchg_start      (fchg_start),
    .clk_stable      (clk_stable),
    .ready           (ready),
    .cke             (cke),
    .cmd_pre_all     (cmd_pre_all),
    .cmd_emrs_dll_rst(cmd_emrs_dll_rst),
    .cmd_mrs         (cmd_mrs),
    .freq_change_req (freq_change_req)
);

// File: tb/dram_fchg_seq_bench.sv
`timescale 1ns/1ps
module dram_fchg_seq_bench;
    localparam int P_RP     = 3;
    localparam int P_CKE    = 2;
    localparam int P_XP     = 2;
    localparam int P_MRD    = 2;
    localparam int P_RELOCK = 40;

    // vector bits: {ready, cke, pre_all, emrs, mrs, freq_req}
    localparam logic [5:0] V_IDLE = 6'b110000;
    localparam logic [5:0] V_BUSY = 6'b010000;
    localparam logic [5:0] V_PRE  = 6'b011000;
    localparam logic [5:0] V_PD   = 6'b000000;
    localparam logic [5:0] V_FREQ = 6'b000001;
    localparam logic [5:0] V_EMRS = 6'b010100;
    localparam logic [5:0] V_MRS  = 6'b010010;

    logic clk = 1'b0;
    logic rst, fchg_start, bank_open, upd_cl_en, clk_stable;
    logic ready, cke, cmd_pre_all, cmd_emrs_dll_rst, cmd_mrs, freq_change_req;

    always #2 clk = ~clk;

    dram_fchg_seq #(
        .T_RP(P_RP), .T_CKE(P_CKE), .T_XP(P_XP), .T_MRD(P_MRD), .T_RELOCK(P_RELOCK)
    ) u_dram_fchg_seq (
        .clk(clk), .rst(rst), .fchg_start(fchg_start), .bank_open(bank_open),
        .upd_cl_en(upd_cl_en), .clk_stable(clk_stable), .ready(ready), .cke(cke),
        .cmd_pre_all(cmd_pre_all), .cmd_emrs_dll_rst(cmd_emrs_dll_rst),
        .cmd_mrs(cmd_mrs), .freq_change_req(freq_change_req)
    );

    typedef struct {
        logic [5:0] v;
        int         tag;
    } ent_t;

    ent_t q[$];
    ent_t cur;
    bit   tail_freq;
    bit   upd_m;
    bit   started;
    bit   finished;
    int   n_checks;
    int   n_fail;

    function automatic string tag_name(input int t);
        case (t)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic void push(input logic [5:0] v, input int t);
        ent_t e;
        e.v   = v;
        e.tag = t;
        q.push_back(e);
    endfunction

    initial begin
        cur.v     = V_IDLE;
        cur.tag   = 1;
        tail_freq = 1'b0;
        upd_m     = 1'b0;
        started   = 1'b0;
        finished  = 1'b0;
        n_checks  = 0;
        n_fail    = 0;
    end

    // reference model: advances on each rising edge
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            q.delete();
            tail_freq = 1'b0;
            cur.v     = V_IDLE;
            cur.tag   = 1;
        end else begin
            if (cur.v[5] && fchg_start) begin
                upd_m = upd_cl_en;
                if (bank_open) begin
                    push(V_PRE, 3);
                    for (int i = 0; i < P_RP; i++) push(V_BUSY, 3);
                    push(V_PD, 3);
                end else begin
                    push(V_PD, 4);
                end
                for (int i = 1; i < ((P_CKE < 2) ? 2 : P_CKE); i++) push(V_PD, 5);
                tail_freq = 1'b1;
            end else if (cur.v[0] && clk_stable) begin
                for (int i = 0; i < P_XP; i++) push(V_BUSY, 7);
                push(V_EMRS, 7);
                for (int i = 0; i < P_RELOCK - 1; i++) begin
                    if (upd_m && i == P_MRD) push(V_MRS, 8);
                    else push(V_BUSY, 9);
                end
                tail_freq = 1'b0;
            end
            if (q.size() > 0) begin
                cur = q.pop_front();
            end else if (tail_freq) begin
                cur.v   = V_FREQ;
                cur.tag = 6;
            end else begin
                cur.v   = V_IDLE;
                cur.tag = (cur.tag == 1) ? 1 : 2;
            end
        end
    end

    // compare half a cycle after each update
    always @(negedge clk) begin
        if (started && !finished) begin
            logic [5:0] dut_v;
            dut_v = {ready, cke, cmd_pre_all, cmd_emrs_dll_rst, cmd_mrs, freq_change_req};
            n_checks++;
            if (dut_v !== cur.v) begin
                n_fail++;
                $display("FAIL %s: outputs {rdy,cke,pre,emrs,mrs,freq} got %b expected %b at %0t",
                         tag_name(cur.tag), dut_v, cur.v, $time);
            end
            n_checks++;
            if ($countones({cmd_pre_all, cmd_emrs_dll_rst, cmd_mrs}) > 1 ||
                (ready === 1'b1 && (cmd_pre_all || cmd_emrs_dll_rst || cmd_mrs || freq_change_req))) begin
                n_fail++;
                $display("FAIL R10: strobes got %b expected at most one and none while ready",
                         {cmd_pre_all, cmd_emrs_dll_rst, cmd_mrs, freq_change_req});
            end
        end
    end

    task automatic wait_freq();
        while (freq_change_req !== 1'b1) @(negedge clk);
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (ready !== 1'b1) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2: watchdog expired, got hung sequence expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; fchg_start = 1'b0; bank_open = 1'b0; upd_cl_en = 1'b0; clk_stable = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // S1: bank open, CAS update, busy-time request and flag changes (R2, R3, R8)
        bank_open = 1'b1; upd_cl_en = 1'b1; fchg_start = 1'b1;
        @(negedge clk);
        fchg_start = 1'b0; upd_cl_en = 1'b0; bank_open = 1'b0;
        repeat (2) @(negedge clk);
        fchg_start = 1'b1;
        @(negedge clk);
        fchg_start = 1'b0;
        wait_freq();
        repeat (3) @(negedge clk);
        clk_stable = 1'b1;
        @(negedge clk);
        clk_stable = 1'b0;
        repeat (10) @(negedge clk);
        fchg_start = 1'b1;           // ignored during relock (R2)
        @(negedge clk);
        fchg_start = 1'b0;
        wait_ready();
        repeat (3) @(negedge clk);

        // S2: no bank open, stable held early (R4, R6)
        bank_open = 1'b0; upd_cl_en = 1'b0; clk_stable = 1'b1; fchg_start = 1'b1;
        @(negedge clk);
        fchg_start = 1'b0;
        wait_freq();
        @(negedge clk);
        clk_stable = 1'b0;
        wait_ready();
        repeat (2) @(negedge clk);

        // S3: request held high, back-to-back sequences (R2, R9)
        bank_open = 1'b1; upd_cl_en = 1'b0; fchg_start = 1'b1;
        wait_freq();
        clk_stable = 1'b1;
        @(negedge clk);
        clk_stable = 1'b0;
        wait_ready();
        @(negedge clk);
        fchg_start = 1'b0;
        wait_freq();
        repeat (6) @(negedge clk);
        clk_stable = 1'b1;
        @(negedge clk);
        clk_stable = 1'b0;
        wait_ready();

        // S4: no bank, CAS update, stable pulse while not requesting (R6, R8)
        repeat (2) @(negedge clk);
        clk_stable = 1'b1;
        @(negedge clk);
        clk_stable = 1'b0;
        bank_open = 1'b0; upd_cl_en = 1'b1; fchg_start = 1'b1;
        @(negedge clk);
        fchg_start = 1'b0;
        wait_freq();
        repeat (5) @(negedge clk);
        clk_stable = 1'b1;
        @(negedge clk);
        clk_stable = 1'b0;
        wait_ready();
        repeat (4) @(negedge clk);

        // reset in mid-sequence returns to idle (R1)
        bank_open = 1'b1; fchg_start = 1'b1;
        @(negedge clk);
        fchg_start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule